// File: doc/BRIEF.md
# Next-PC Sequencer with Zero-Overhead Loop and Debug Trap

This block closes every instruction step by choosing the program counter for the next step. It owns the 16-bit word-address PC, the 16-bit status word and the loop counter. On each step it takes the sequential successor PC and a taken-branch indication from the execution stage. It then folds in zero-overhead loop redirection, an instruction-address breakpoint, and the two fault redirections: bus error and illegal instruction.

A loop is armed by a load strobe that writes the counter and sets the status word's loop-active bit. The bounds are the loop start and loop end addresses. When the step at the loop end finishes with no branch, control returns to the loop start and the counter steps down, until the last pass lets execution fall through. The breakpoint compares the PC against a programmed address while the status word's debug-enable bit is set. The breakpoint and the faults replace the PC with a vector and mask the status word. In the same edge they save the PC and status word of the interrupted step into backup registers.

Top module: `npc_sequencer`

## Requirements
- R1: A synchronous active-low reset sets the PC to RESET_PC (default 0x0000) and sets the status word, the loop counter and both backup registers to zero.
- R2: With `step_en` high and no fault, breakpoint, branch or loop-end hit, the PC takes `seq_pc`. With `step_en` low, the PC, status word, counter and backup registers hold.
- R3: A taken branch sets the PC to `br_target`, even when the PC equals the loop end with the loop active (status bit 12). In that step the counter and the loop-active bit are unchanged.
- R4: A loop-end hit is a step with no branch, status bit 12 set and PC equal to `rpt_end`. On a hit with a counter above 1, the PC becomes `rpt_start` and the counter drops by one.
- R5: On a loop-end hit with a counter of 1 or 0, the PC takes `seq_pc`, status bit 12 clears and the counter keeps its value.
- R6: With status bit 12 clear, or with the PC away from `rpt_end`, no loop redirection or counter change happens.
- R7: A breakpoint fires when status bit 14 (debug enable) is set and the PC equals `bp_addr`. The PC then becomes DBG_VEC (default 0x0FF4) and the status word keeps only bit 15 (stack mode). This overrides any branch or loop and leaves the counter unchanged.
- R8: A bus error sends the PC to AE_VEC (default 0x0FF8) and an illegal instruction sends it to RIE_VEC (default 0x0FFC). In both cases the status word keeps only bits 3, 2 and 0 (F0, F1, carry). A bus error outranks an illegal instruction, and both outrank a breakpoint.
- R9: In the edge where a fault or breakpoint redirects, the backup registers capture the PC and status word the step started with. At all other times they hold.
- R10: `psw_wr` replaces the status word, and `rpt_load` loads the counter from `rpt_count` and sets status bit 12. Both are ignored in a step that takes a fault or breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | An instruction step completes this cycle |
| seq_pc | input | 16 | Sequential successor PC |
| br_taken | input | 1 | The step took a branch |
| br_target | input | 16 | Branch destination |
| rpt_load | input | 1 | Load the loop counter and arm the loop |
| rpt_count | input | 16 | Iteration count for `rpt_load` |
| rpt_start | input | 16 | First PC of the loop body |
| rpt_end | input | 16 | Last PC of the loop body |
| bp_addr | input | 16 | Breakpoint instruction address |
| psw_wr | input | 1 | Status word write from execution |
| psw_wdata | input | 16 | Status word write data |
| bus_err | input | 1 | The step raised a bus error |
| ill_insn | input | 1 | The step hit an illegal instruction |
| pc | output | 16 | Current PC |
| psw | output | 16 | Current status word |
| rpt_cnt | output | 16 | Current loop counter |
| bkp_pc | output | 16 | PC saved at the last redirection |
| bkp_psw | output | 16 | Status word saved at the last redirection |

## Verification
Two pairs of functions can collide in one step. A branch and a loop-end hit collide when the branch itself sits at the loop end. A breakpoint collides with a branch, with loop state updates and with status writes when the breakpoint address is placed on a branching instruction. The bench steers the PC onto the loop end or the breakpoint address with a branch, then raises the competing input in the next step. It judges the winner from the next PC, and the loser from the counter and status word left behind. A separate step raises bus error and illegal instruction together to confirm their ranking.

// File: rtl/npc_pkg.sv
// Shared constants for the next-PC sequencer: status-word bit positions
// and the masks applied on trap entry. Assumes a 16-bit status word.
package npc_pkg;
    localparam int PSW_W  = 16;
    localparam int SM_BIT = 15;   // stack mode
    localparam int DB_BIT = 14;   // debug enable
    localparam int RP_BIT = 12;   // loop active
    localparam int F0_BIT = 3;
    localparam int F1_BIT = 2;
    localparam int CY_BIT = 0;

    localparam logic [PSW_W-1:0] KEEP_ON_FAULT =
        (PSW_W'(1) << F0_BIT) | (PSW_W'(1) << F1_BIT) | (PSW_W'(1) << CY_BIT);
    localparam logic [PSW_W-1:0] KEEP_ON_BKPT = PSW_W'(1) << SM_BIT;
endpackage

// File: rtl/npc_trap_unit.sv
// Trap selection: decides whether the finishing step is redirected by a
// bus error, an illegal instruction or the instruction breakpoint, and
// supplies the vector and the masked status word. Purely combinational;
// assumes the caller qualifies the result with the step strobe.
module npc_trap_unit
    import npc_pkg::*;
#(
    parameter int          PC_W    = 16,
    parameter logic [15:0] AE_VEC  = 16'h0FF8,
    parameter logic [15:0] RIE_VEC = 16'h0FFC,
    parameter logic [15:0] DBG_VEC = 16'h0FF4
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PSW_W-1:0] cur_psw,
    input  logic [PC_W-1:0]  bp_addr,
    input  logic             bus_err,
    input  logic             ill_insn,
    output logic             trap_hit,
    output logic             bkpt_hit,
    output logic [PC_W-1:0]  trap_pc,
    output logic [PSW_W-1:0] trap_psw
);
    // Breakpoint match: debug enabled and PC on the programmed address.
    always_comb bkpt_hit = cur_psw[DB_BIT] && (cur_pc == bp_addr);

    // Fixed priority: bus error, illegal instruction, breakpoint.
    always_comb begin
        trap_hit = 1'b1;
        trap_pc  = PC_W'(AE_VEC);
        trap_psw = cur_psw & KEEP_ON_FAULT;
        if (bus_err) begin
            trap_pc  = PC_W'(AE_VEC);
            trap_psw = cur_psw & KEEP_ON_FAULT;
        end else if (ill_insn) begin
            trap_pc  = PC_W'(RIE_VEC);
            trap_psw = cur_psw & KEEP_ON_FAULT;
        end else if (bkpt_hit) begin
            trap_pc  = PC_W'(DBG_VEC);
            trap_psw = cur_psw & KEEP_ON_BKPT;
        end else begin
            trap_hit = 1'b0;
        end
    end
endmodule

// File: rtl/npc_loop_unit.sv
// Normal-flow next PC: taken branch, then loop-end redirection, then the
// sequential successor. Computes the counter update and the loop-exit
// request. Combinational; assumes traps are applied by the caller.
module npc_loop_unit #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic             loop_on,
    input  logic [PC_W-1:0]  rpt_start,
    input  logic [PC_W-1:0]  rpt_end,
    input  logic [CNT_W-1:0] cnt,
    input  logic [PC_W-1:0]  seq_pc,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_target,
    output logic [PC_W-1:0]  flow_pc,
    output logic [CNT_W-1:0] flow_cnt,
    output logic             loop_exit,
    output logic             loop_back
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic at_end;
    logic last_pass;

    // Loop-end hit only when no branch redirected this step.
    always_comb at_end = loop_on && !br_taken && (cur_pc == rpt_end);

    // Final pass: counter at one, or already exhausted.
    always_comb last_pass = (cnt <= CNT_ONE);

    // Loop-back and loop-exit decisions.
    always_comb begin
        loop_back = at_end && !last_pass;
        loop_exit = at_end && last_pass;
    end

    // Next PC and counter for the non-trap path.
    always_comb begin
        flow_cnt = cnt;
        if (br_taken) begin
            flow_pc = br_target;
        end else if (loop_back) begin
            flow_pc  = rpt_start;
            flow_cnt = cnt - CNT_ONE;
        end else begin
            flow_pc = seq_pc;
        end
    end
endmodule

// File: rtl/npc_sequencer.sv
// Next-PC sequencer top: holds PC, status word, loop counter and the trap
// backup registers, and commits one step per step_en. Traps outrank the
// normal flow; a trapping step discards status writes and loop loads.
module npc_sequencer
    import npc_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter int          CNT_W    = 16,
    parameter logic [15:0] RESET_PC = 16'h0000,
    parameter logic [15:0] AE_VEC   = 16'h0FF8,
    parameter logic [15:0] RIE_VEC  = 16'h0FFC,
    parameter logic [15:0] DBG_VEC  = 16'h0FF4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [PC_W-1:0]  seq_pc,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic             rpt_load,
    input  logic [CNT_W-1:0] rpt_count,
    input  logic [PC_W-1:0]  rpt_start,
    input  logic [PC_W-1:0]  rpt_end,
    input  logic [PC_W-1:0]  bp_addr,
    input  logic             psw_wr,
    input  logic [PSW_W-1:0] psw_wdata,
    input  logic             bus_err,
    input  logic             ill_insn,
    output logic [PC_W-1:0]  pc,
    output logic [PSW_W-1:0] psw,
    output logic [CNT_W-1:0] rpt_cnt,
    output logic [PC_W-1:0]  bkp_pc,
    output logic [PSW_W-1:0] bkp_psw
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [PC_W-1:0]  pc_q, bkp_pc_q, trap_pc, flow_pc;
    logic [PSW_W-1:0] psw_q, bkp_psw_q, trap_psw, flow_psw;
    logic [CNT_W-1:0] cnt_q, flow_cnt;
    logic             trap_hit, bkpt_hit, loop_exit, loop_back;

    npc_trap_unit #(
        .PC_W(PC_W), .AE_VEC(AE_VEC), .RIE_VEC(RIE_VEC), .DBG_VEC(DBG_VEC)
    ) u_trap (
        .cur_pc  (pc_q),
        .cur_psw (psw_q),
        .bp_addr (bp_addr),
        .bus_err (bus_err),
        .ill_insn(ill_insn),
        .trap_hit(trap_hit),
        .bkpt_hit(bkpt_hit),
        .trap_pc (trap_pc),
        .trap_psw(trap_psw)
    );

    npc_loop_unit #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
        .cur_pc   (pc_q),
        .loop_on  (psw_q[RP_BIT]),
        .rpt_start(rpt_start),
        .rpt_end  (rpt_end),
        .cnt      (cnt_q),
        .seq_pc   (seq_pc),
        .br_taken (br_taken),
        .br_target(br_target),
        .flow_pc  (flow_pc),
        .flow_cnt (flow_cnt),
        .loop_exit(loop_exit),
        .loop_back(loop_back)
    );

    // Status word for a non-trapping step: write, then arm, then loop exit.
    always_comb begin
        flow_psw = psw_wr ? psw_wdata : psw_q;
        if (rpt_load)  flow_psw[RP_BIT] = 1'b1;
        if (loop_exit) flow_psw[RP_BIT] = 1'b0;
    end

    // Step commit: trap redirection with backup, or the normal flow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= PC_W'(RESET_PC);
            psw_q     <= '0;
            cnt_q     <= '0;
            bkp_pc_q  <= '0;
            bkp_psw_q <= '0;
        end else if (step_en) begin
            if (trap_hit) begin
                pc_q      <= trap_pc;
                psw_q     <= trap_psw;
                bkp_pc_q  <= pc_q;
                bkp_psw_q <= psw_q;
            end else begin
                pc_q  <= flow_pc;
                psw_q <= flow_psw;
                cnt_q <= rpt_load ? rpt_count : flow_cnt;
            end
        end
    end

    assign pc      = pc_q;
    assign psw     = psw_q;
    assign rpt_cnt = cnt_q;
    assign bkp_pc  = bkp_pc_q;
    assign bkp_psw = bkp_psw_q;

    // R2: an idle cycle leaves all architectural state alone.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pc_q) && $stable(psw_q) && $stable(cnt_q));

    // R3: a branch without a trap always reaches its target.
    a_r3_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && br_taken && !trap_hit |=> pc_q == $past(br_target));

    // R4: loop-back restarts the body and consumes one iteration.
    a_r4_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !trap_hit && loop_back && !rpt_load
        |=> pc_q == $past(rpt_start) && cnt_q == $past(cnt_q) - CNT_ONE);

    // R5: the last pass falls through and disarms the loop.
    a_r5_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !trap_hit && loop_exit && !rpt_load
        |=> !psw_q[RP_BIT] && pc_q == $past(seq_pc) && $stable(cnt_q));

    // R7: breakpoint entry leaves only the stack-mode bit.
    a_r7_bkpt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && bkpt_hit && !bus_err && !ill_insn
        |=> pc_q == PC_W'(DBG_VEC) && (psw_q & ~KEEP_ON_BKPT) == '0
            && $stable(cnt_q));

    // R8: a bus error wins and keeps only the flag bits.
    a_r8_bus_fault: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && bus_err
        |=> pc_q == PC_W'(AE_VEC) && (psw_q & ~KEEP_ON_FAULT) == '0);

    // R9: backups move only on a trapping step, and then to the old state.
    a_r9_backup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_en && trap_hit) |=> $stable(bkp_pc_q) && $stable(bkp_psw_q));
    a_r9_backup_take: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && trap_hit |=> bkp_pc_q == $past(pc_q) && bkp_psw_q == $past(psw_q));
endmodule

// File: tb/tb_npc_sequencer.sv
module tb_npc_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    typedef struct packed {
        logic        en;
        logic [15:0] seq;
        logic        br;
        logic [15:0] tgt;
        logic        ld;
        logic [15:0] ldc;
        logic        pw;
        logic [15:0] pwd;
        logic        be;
        logic        ie;
        logic [15:0] e_pc;
        logic [15:0] e_psw;
        logic [15:0] e_cnt;
        logic [15:0] e_bpc;
        logic [15:0] e_bpsw;
        logic [3:0]  req;
    } vec_t;

    // Loop body 0x20..0x24, breakpoint at 0x40; status bits: 15 SM, 14 DB, 12 loop.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,16'h0001,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0001,16'h0000,16'd0,16'h0000,16'h0000, 4'd2},  // R2 sequential
        '{1'b0,16'h0055,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0001,16'h0000,16'd0,16'h0000,16'h0000, 4'd2},  // R2 idle
        '{1'b1,16'h0002,1'b0,16'h0000,1'b1,16'd3,1'b0,16'h0000,1'b0,1'b0, 16'h0002,16'h1000,16'd3,16'h0000,16'h0000, 4'd10}, // R10 arm
        '{1'b1,16'h0003,1'b1,16'h0024,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0024,16'h1000,16'd3,16'h0000,16'h0000, 4'd3},
        '{1'b1,16'h0025,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0020,16'h1000,16'd2,16'h0000,16'h0000, 4'd4},  // R4
        '{1'b1,16'h0021,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0021,16'h1000,16'd2,16'h0000,16'h0000, 4'd6},  // R6 off end
        '{1'b1,16'h0022,1'b1,16'h0024,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0024,16'h1000,16'd2,16'h0000,16'h0000, 4'd3},
        '{1'b1,16'h0025,1'b1,16'h0030,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0030,16'h1000,16'd2,16'h0000,16'h0000, 4'd3},  // R3 branch at end
        '{1'b1,16'h0031,1'b1,16'h0024,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0024,16'h1000,16'd2,16'h0000,16'h0000, 4'd3},
        '{1'b1,16'h0025,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0020,16'h1000,16'd1,16'h0000,16'h0000, 4'd4},  // R4
        '{1'b1,16'h0021,1'b1,16'h0024,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0024,16'h1000,16'd1,16'h0000,16'h0000, 4'd3},
        '{1'b1,16'h0025,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0025,16'h0000,16'd1,16'h0000,16'h0000, 4'd5},  // R5 last pass
        '{1'b1,16'h0026,1'b1,16'h0024,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0024,16'h0000,16'd1,16'h0000,16'h0000, 4'd3},
        '{1'b1,16'h0025,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0025,16'h0000,16'd1,16'h0000,16'h0000, 4'd6},  // R6 disarmed
        '{1'b1,16'h0026,1'b0,16'h0000,1'b0,16'd0,1'b1,16'hD00D,1'b0,1'b0, 16'h0026,16'hD00D,16'd1,16'h0000,16'h0000, 4'd10}, // R10 write
        '{1'b1,16'h0027,1'b1,16'h0040,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0040,16'hD00D,16'd1,16'h0000,16'h0000, 4'd3},
        '{1'b1,16'h0041,1'b1,16'h0050,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0FF4,16'h8000,16'd1,16'h0040,16'hD00D, 4'd7},  // R7 over branch
        '{1'b1,16'h0FF5,1'b1,16'h0024,1'b1,16'd5,1'b1,16'h500D,1'b0,1'b0, 16'h0024,16'h500D,16'd5,16'h0040,16'hD00D, 4'd10},
        '{1'b1,16'h0025,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b1,1'b0, 16'h0FF8,16'h000D,16'd5,16'h0024,16'h500D, 4'd8},  // R8 bus error at loop end
        '{1'b1,16'h0FF9,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b0, 16'h0FF9,16'h000D,16'd5,16'h0024,16'h500D, 4'd2},
        '{1'b1,16'h0FFA,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b0,1'b1, 16'h0FFC,16'h000D,16'd5,16'h0FF9,16'h000D, 4'd8},  // R8 illegal
        '{1'b1,16'h0FFD,1'b0,16'h0000,1'b0,16'd0,1'b0,16'h0000,1'b1,1'b1, 16'h0FF8,16'h000D,16'd5,16'h0FFC,16'h000D, 4'd8}   // R8 ranking
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0, br_taken = 1'b0, rpt_load = 1'b0, psw_wr = 1'b0;
    logic        bus_err = 1'b0, ill_insn = 1'b0;
    logic [15:0] seq_pc = '0, br_target = '0, rpt_count = '0, psw_wdata = '0;
    logic [15:0] rpt_start = 16'h0020, rpt_end = 16'h0024, bp_addr = 16'h0040;
    logic [15:0] pc, psw, rpt_cnt, bkp_pc, bkp_psw;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_sequencer #(
        .PC_W(16), .CNT_W(16), .RESET_PC(16'h0000),
        .AE_VEC(16'h0FF8), .RIE_VEC(16'h0FFC), .DBG_VEC(16'h0FF4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .seq_pc(seq_pc),
        .br_taken(br_taken), .br_target(br_target), .rpt_load(rpt_load),
        .rpt_count(rpt_count), .rpt_start(rpt_start), .rpt_end(rpt_end),
        .bp_addr(bp_addr), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
        .bus_err(bus_err), .ill_insn(ill_insn), .pc(pc), .psw(psw),
        .rpt_cnt(rpt_cnt), .bkp_pc(bkp_pc), .bkp_psw(bkp_psw)
    );

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic [15:0] e_pc,
                             input logic [15:0] e_psw, input logic [15:0] e_cnt,
                             input logic [15:0] e_bpc, input logic [15:0] e_bpsw);
        check(req, "pc", pc, e_pc);
        check(req, "psw", psw, e_psw);
        check(req, "count", rpt_cnt, e_cnt);
        check(req, "backup pc", bkp_pc, e_bpc);
        check(req, "backup psw", bkp_psw, e_bpsw);
    endtask

    // Drive one step at the falling edge, commit on the rising edge, sample at the next fall.
    task automatic do_step(input logic en, input logic [15:0] sq, input logic br,
                           input logic [15:0] tg, input logic ld, input logic [15:0] ldc,
                           input logic pw, input logic [15:0] pwd,
                           input logic be, input logic ie);
        step_en = en; seq_pc = sq; br_taken = br; br_target = tg;
        rpt_load = ld; rpt_count = ldc; psw_wr = pw; psw_wdata = pwd;
        bus_err = be; ill_insn = ie;
        @(posedge clk);
        @(negedge clk);
        step_en = 1'b0; br_taken = 1'b0; rpt_load = 1'b0; psw_wr = 1'b0;
        bus_err = 1'b0; ill_insn = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        check_all(1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            do_step(VECS[i].en, VECS[i].seq, VECS[i].br, VECS[i].tgt, VECS[i].ld,
                    VECS[i].ldc, VECS[i].pw, VECS[i].pwd, VECS[i].be, VECS[i].ie);
            check_all(int'(VECS[i].req), VECS[i].e_pc, VECS[i].e_psw, VECS[i].e_cnt,
                      VECS[i].e_bpc, VECS[i].e_bpsw);
        end

        // R1: reset during an active step clears everything, backups included.
        rst_n = 1'b0;
        do_step(1'b1, 16'h0123, 1'b1, 16'h0456, 1'b1, 16'd7, 1'b1, 16'hFFFF, 1'b0, 1'b0);
        check_all(1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        rst_n = 1'b1;

        // R5: exhausted counter (0) at the loop end also exits.
        do_step(1'b1, 16'h0001, 1'b1, 16'h0024, 1'b0, 16'd0, 1'b1, 16'h1000, 1'b0, 1'b0);
        check_all(5, 16'h0024, 16'h1000, 16'h0000, 16'h0000, 16'h0000);
        do_step(1'b1, 16'h0025, 1'b0, 16'h0000, 1'b0, 16'd0, 1'b0, 16'h0000, 1'b0, 1'b0);
        check_all(5, 16'h0025, 16'h0000, 16'h0000, 16'h0000, 16'h0000);

        // R10 / R9: breakpoint step discards status write and counter load.
        do_step(1'b1, 16'h0026, 1'b1, 16'h0040, 1'b0, 16'd0, 1'b1, 16'h4000, 1'b0, 1'b0);
        check_all(10, 16'h0040, 16'h4000, 16'h0000, 16'h0000, 16'h0000);
        do_step(1'b1, 16'h0041, 1'b0, 16'h0000, 1'b1, 16'd9, 1'b1, 16'h0FFF, 1'b0, 1'b0);
        check_all(10, 16'h0FF4, 16'h0000, 16'h0000, 16'h0040, 16'h4000);
        // R9: backups hold across a normal step.
        do_step(1'b1, 16'h0FF5, 1'b0, 16'h0000, 1'b0, 16'd0, 1'b0, 16'h0000, 1'b0, 1'b0);
        check_all(9, 16'h0FF5, 16'h0000, 16'h0000, 16'h0040, 16'h4000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule